// File: doc/BRIEF.md
# Nibble-Serial BCH Remainder Engine

This block divides a NAND sector stream, taken four bits at a time, by a fixed BCH generator polynomial over GF(2) and holds the remainder. A sector starts with a pulse on `start_sector`. The sector is made of three parts, taken in this order:

- the data nibbles;
- an included spare segment, whose nibbles also go through the divider;
- a skipped spare segment, whose nibbles are counted but left out.

The same engine serves both directions of a NAND transfer.

- **Write:** set the included length to zero and the skipped length to the parity size. The remainder is then the parity to store.
- **Read:** set the included length to the parity size and stream the stored parity after the data. An error-free sector then leaves a zero remainder, and `is_zero` tells software that error location can be skipped.

The correction strength selects the remainder length: 104 bits or 208 bits. The generator polynomials are synthesis parameters. When a sector's last counted nibble has been taken, a one-cycle `done` pulse marks the result. Further input is then ignored until the next sector starts.

Top module: `nib_bch_rem`

## Requirements
- R1: After reset, and in the cycle after `start_sector`, `remainder` is all zeros. A nibble offered in the same cycle as `start_sector` is not taken.
- R2: Let D be the remainder degree and B(x) the polynomial of the divided bits. Each accepted nibble supplies four bits, `nib_in[3]` first. `remainder` equals B(x)·x^D mod g(x), where g(x) = x^D + the polynomial parameter for the selected strength.
- R3: `strength` is captured at `start_sector`. A value of 0 gives D=104, and `remainder[207:104]` then stays zero. A value of 1 gives D=208.
- R4: After `start_sector`, the accepted nibbles are handled in this order: first `data_len` data nibbles, then `size0` nibbles that are divided, then `size1` nibbles that are counted but do not change `remainder`. The lengths are captured at start.
- R5: Write use: with sizes 0/P, the remainder is the parity of the data. Read use: stream that parity after the data, most significant nibble first (nibble k is `remainder[D-1-4k -: 4]`), with sizes P/0. The remainder is then zero. A single flipped data bit makes it nonzero.
- R6: `is_zero` is 1 exactly when `remainder` is all zeros.
- R7: A cycle with `nib_valid` low neither advances the counters nor changes `remainder`, whatever `nib_in` carries.
- R8: `done` is a one-cycle pulse. It is high in the cycle after the edge that took the last counted nibble. If all three lengths are zero, it is high in the cycle after `start_sector`. At no other time is it high.
- R9: After the last counted nibble, further valid nibbles change neither `remainder` nor `done` until the next `start_sector`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_sector | input | 1 | Clears the remainder and captures the lengths and strength |
| strength | input | 1 | 0: 104-bit remainder, 1: 208-bit remainder |
| data_len | input | 12 | Data nibbles per sector |
| size0 | input | 8 | Spare nibbles that are divided |
| size1 | input | 8 | Spare nibbles that are skipped |
| nib_valid | input | 1 | Qualifies `nib_in` |
| nib_in | input | 4 | Stream nibble, MSB first in time |
| done | output | 1 | One-cycle end-of-sector pulse |
| remainder | output | 208 | Division remainder, right-aligned |
| is_zero | output | 1 | Remainder is all zeros |

## Verification
Every nibble is absorbed on the rising edge where `nib_valid` is high, so `remainder` and `done` reflect that nibble one edge later. The bench drives on the falling edge and reads at the next falling edge. After each nibble it checks `done`: low after every nibble but the last, high after the last. For an empty sector, `done` must be high at the first falling edge after the start edge. Expected remainders come from a bit-serial long division of the nibbles the requirements declare divided. `remainder` is compared once the `done` sample has been taken, and again after post-`done` traffic.

// File: rtl/nib_bch_pkg.sv
package nib_bch_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_INCL = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

endpackage

// File: rtl/nib_bch_seq.sv
module nib_bch_seq
    import nib_bch_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int SZ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] dlen,
    input  logic [SZ_W-1:0]  s0,
    input  logic [SZ_W-1:0]  s1,
    input  logic             valid,
    output logic             absorb,
    output logic             busy,
    output logic             done
);

    localparam int PAD = LEN_W - SZ_W;

    typedef struct packed {
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] l_data;
        logic [LEN_W-1:0] l_inc;
        logic [LEN_W-1:0] l_skip;
        logic             done;
    } seq_t;

    seq_t st_d, st_q;
    logic [LEN_W-1:0] cur_len;
    phase_e           nxt_ph;

    // First non-empty segment after the one that just ended.
    function automatic phase_e pick(input phase_e after, input logic [LEN_W-1:0] ld,
                                    input logic [LEN_W-1:0] li, input logic [LEN_W-1:0] ls);
        phase_e p;
        p = PH_IDLE;
        if (after == PH_IDLE && ld != '0)                      p = PH_DATA;
        else if ((after == PH_IDLE || after == PH_DATA) && li != '0) p = PH_INCL;
        else if (after != PH_SKIP && ls != '0)                 p = PH_SKIP;
        return p;
    endfunction

    always_comb begin
        st_d    = st_q;
        st_d.done = 1'b0;
        cur_len = '0;
        nxt_ph  = PH_IDLE;
        unique case (st_q.ph)
            PH_DATA: cur_len = st_q.l_data;
            PH_INCL: cur_len = st_q.l_inc;
            PH_SKIP: cur_len = st_q.l_skip;
            default: cur_len = '0;
        endcase
        if (start) begin
            st_d.l_data = dlen;
            st_d.l_inc  = {{PAD{1'b0}}, s0};
            st_d.l_skip = {{PAD{1'b0}}, s1};
            st_d.cnt    = '0;
            st_d.ph     = pick(PH_IDLE, dlen, {{PAD{1'b0}}, s0}, {{PAD{1'b0}}, s1});
            st_d.done   = (st_d.ph == PH_IDLE);
        end else if (valid && st_q.ph != PH_IDLE) begin
            if (st_q.cnt == cur_len - 1'b1) begin
                nxt_ph    = pick(st_q.ph, st_q.l_data, st_q.l_inc, st_q.l_skip);
                st_d.ph   = nxt_ph;
                st_d.cnt  = '0;
                st_d.done = (nxt_ph == PH_IDLE);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, l_data: '0, l_inc: '0, l_skip: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign absorb = !start && valid && (st_q.ph == PH_DATA || st_q.ph == PH_INCL);
    assign busy   = (st_q.ph != PH_IDLE);
    assign done   = st_q.done;

    AST_SKIP_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_SKIP) |-> (st_q.cnt < st_q.l_skip)); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !start) |=> !st_q.done); // R8

endmodule

// File: rtl/nib_bch_div.sv
module nib_bch_div #(
    parameter int                DEG_LO  = 104,
    parameter int                DEG_HI  = 208,
    parameter logic [DEG_LO-1:0] POLY_LO = {8'hB5, 88'h0, 8'h8D},
    parameter logic [DEG_HI-1:0] POLY_HI = {8'hC3, 192'h0, 8'h1D},
    parameter int                NIB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              strength,
    input  logic              absorb,
    input  logic [NIB_W-1:0]  nib,
    output logic [DEG_HI-1:0] rem,
    output logic              hi_mode
);

    localparam int GAP = DEG_HI - DEG_LO;
    localparam logic [DEG_HI-1:0] MASK_LO = {{GAP{1'b0}}, {DEG_LO{1'b1}}};
    localparam logic [DEG_HI-1:0] G_LO    = {{GAP{1'b0}}, POLY_LO};

    typedef struct packed {
        logic [DEG_HI-1:0] rem;
        logic              hi;
    } div_t;

    div_t st_d, st_q;
    logic [DEG_HI-1:0] acc;
    logic              fb;

    always_comb begin
        st_d = st_q;
        acc  = st_q.rem;
        fb   = 1'b0;
        if (clear) begin
            st_d.rem = '0;
            st_d.hi  = strength;
        end else if (absorb) begin
            for (int i = NIB_W - 1; i >= 0; i--) begin
                fb  = nib[i] ^ (st_q.hi ? acc[DEG_HI-1] : acc[DEG_LO-1]);
                acc = acc << 1;
                if (!st_q.hi) acc = acc & MASK_LO;
                if (fb) acc = acc ^ (st_q.hi ? POLY_HI : G_LO);
            end
            st_d.rem = acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rem: '0, hi: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rem     = st_q.rem;
    assign hi_mode = st_q.hi;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.rem == '0)); // R1

    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.hi |-> (st_q.rem[DEG_HI-1:DEG_LO] == '0)); // R3

endmodule

// File: rtl/nib_bch_rem.sv
module nib_bch_rem #(
    parameter int                LEN_W   = 12,
    parameter int                SZ_W    = 8,
    parameter int                DEG_LO  = 104,
    parameter int                DEG_HI  = 208,
    parameter logic [DEG_LO-1:0] POLY_LO = {8'hB5, 88'h0, 8'h8D},
    parameter logic [DEG_HI-1:0] POLY_HI = {8'hC3, 192'h0, 8'h1D}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_sector,
    input  logic              strength,
    input  logic [LEN_W-1:0]  data_len,
    input  logic [SZ_W-1:0]   size0,
    input  logic [SZ_W-1:0]   size1,
    input  logic              nib_valid,
    input  logic [3:0]        nib_in,
    output logic              done,
    output logic [DEG_HI-1:0] remainder,
    output logic              is_zero
);

    logic absorb;
    logic busy;
    logic hi_mode;

    nib_bch_seq #(
        .LEN_W(LEN_W),
        .SZ_W (SZ_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_sector),
        .dlen  (data_len),
        .s0    (size0),
        .s1    (size1),
        .valid (nib_valid),
        .absorb(absorb),
        .busy  (busy),
        .done  (done)
    );

    nib_bch_div #(
        .DEG_LO (DEG_LO),
        .DEG_HI (DEG_HI),
        .POLY_LO(POLY_LO),
        .POLY_HI(POLY_HI),
        .NIB_W  (4)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_sector),
        .strength(strength),
        .absorb  (absorb),
        .nib     (nib_in),
        .rem     (remainder),
        .hi_mode (hi_mode)
    );

    assign is_zero = (remainder == '0);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_sector && !busy) |=> $stable(remainder)); // R9

    AST_NO_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_sector && !nib_valid) |=> $stable(remainder)); // R7

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

endmodule

// File: tb/sim_nib_bch_rem.sv
`timescale 1ns/1ps
module sim_nib_bch_rem;

    localparam logic [103:0] P_LO = {8'hB5, 88'h0, 8'h8D};
    localparam logic [207:0] P_HI = {8'hC3, 192'h0, 8'h1D};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_sector = 1'b0;
    logic         strength = 1'b0;
    logic [11:0]  data_len = '0;
    logic [7:0]   size0 = '0;
    logic [7:0]   size1 = '0;
    logic         nib_valid = 1'b0;
    logic [3:0]   nib_in = '0;
    logic         done;
    logic [207:0] remainder;
    logic         is_zero;

    logic [3:0]   stim [0:511];
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    nib_bch_rem u0 (
        .clk(clk), .rst_n(rst_n), .start_sector(start_sector), .strength(strength),
        .data_len(data_len), .size0(size0), .size1(size1), .nib_valid(nib_valid),
        .nib_in(nib_in), .done(done), .remainder(remainder), .is_zero(is_zero)
    );

    task automatic chk(input bit ok, input string req, input logic [207:0] act, input logic [207:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Long division of the first n stimulus nibbles, B(x)*x^D mod g(x).
    function automatic logic [207:0] model(input logic hi, input int n);
        logic [207:0] r;
        int d;
        logic b;
        r = '0;
        d = hi ? 208 : 104;
        for (int k = 0; k < n; k++) begin
            for (int j = 3; j >= 0; j--) begin
                b = stim[k][j] ^ r[d-1];
                r = r << 1;
                if (!hi) r[207:104] = '0;
                if (b) r = r ^ (hi ? P_HI : {104'h0, P_LO});
            end
        end
        return r;
    endfunction

    task automatic put_parity(input logic hi, input int at, input logic [207:0] par);
        int d;
        d = hi ? 208 : 104;
        for (int k = 0; k < d / 4; k++) stim[at + k] = par[d - 1 - 4 * k -: 4];
    endtask

    task automatic run_sector(input logic hi, input int dl, input int s0, input int s1,
                              input bit gaps, input bit junk_at_start, input string tag);
        int total;
        total = dl + s0 + s1;
        @(negedge clk);
        start_sector = 1'b1; strength = hi; data_len = 12'(dl);
        size0 = 8'(s0); size1 = 8'(s1);
        nib_valid = junk_at_start; nib_in = 4'hA;
        @(negedge clk);
        start_sector = 1'b0; nib_valid = 1'b0;
        chk(remainder == '0, {tag, " R1 cleared at start"}, remainder, '0);
        if (total == 0)
            chk(done == 1'b1, {tag, " R8 empty sector done"}, {207'h0, done}, 208'h1);
        for (int k = 0; k < total; k++) begin
            if (gaps && (k % 3 == 1)) begin
                nib_valid = 1'b0; nib_in = ~stim[k];
                @(negedge clk);
                chk(done == 1'b0, {tag, " R7 gap no done"}, {207'h0, done}, '0);
            end
            nib_valid = 1'b1; nib_in = stim[k];
            @(negedge clk);
            nib_valid = 1'b0;
            chk(done == (k == total - 1), {tag, " R8 done timing"}, {207'h0, done},
                {207'h0, (k == total - 1)});
        end
        @(negedge clk);
        chk(done == 1'b0, {tag, " R8 single pulse"}, {207'h0, done}, '0);
        chk(remainder == model(hi, dl + s0), {tag, " R2 R4 remainder"}, remainder, model(hi, dl + s0));
        chk(is_zero == (remainder == '0), {tag, " R6 zero flag"}, {207'h0, is_zero},
            {207'h0, (remainder == '0)});
    endtask

    task automatic t_reset();
        chk(remainder == '0, "R1 reset remainder", remainder, '0);
        chk(done == 1'b0, "R8 reset done", {207'h0, done}, '0);
        chk(is_zero == 1'b1, "R6 reset zero flag", {207'h0, is_zero}, 208'h1);
    endtask

    task automatic t_write_read(input logic hi, input int dl);
        logic [207:0] par;
        int p;
        p = hi ? 52 : 26;
        for (int k = 0; k < dl; k++) stim[k] = 4'($urandom);
        for (int k = dl; k < dl + p; k++) stim[k] = 4'($urandom);
        run_sector(hi, dl, 0, p, 1'b0, 1'b0, "write");
        par = remainder;
        chk(par == model(hi, dl), "R5 write parity", par, model(hi, dl));
        if (!hi) chk(par[207:104] == '0, "R3 short upper bits", par, '0);
        put_parity(hi, dl, par);
        run_sector(hi, dl, p, 0, 1'b0, 1'b0, "read");
        chk(remainder == '0, "R5 clean read zero", remainder, '0);
        chk(is_zero == 1'b1, "R6 clean read flag", {207'h0, is_zero}, 208'h1);
        stim[3] = stim[3] ^ 4'h4;
        run_sector(hi, dl, p, 0, 1'b0, 1'b0, "readerr");
        chk(remainder != '0, "R5 corrupt read nonzero", remainder, model(hi, dl + p));
        chk(is_zero == 1'b0, "R6 corrupt read flag", {207'h0, is_zero}, '0);
    endtask

    task automatic t_mixed_gaps();
        for (int k = 0; k < 40; k++) stim[k] = 4'($urandom);
        run_sector(1'b1, 30, 4, 6, 1'b1, 1'b0, "mixed");
    endtask

    task automatic t_after_done();
        logic [207:0] held;
        held = remainder;
        for (int k = 0; k < 5; k++) begin
            nib_valid = 1'b1; nib_in = 4'(k + 3);
            @(negedge clk);
            chk(done == 1'b0, "R9 no done after end", {207'h0, done}, '0);
        end
        nib_valid = 1'b0;
        chk(remainder == held, "R9 remainder held", remainder, held);
    endtask

    task automatic t_empty_and_start_junk();
        run_sector(1'b0, 0, 0, 0, 1'b0, 1'b0, "empty");
        chk(remainder == '0, "R1 empty remainder", remainder, '0);
        for (int k = 0; k < 5; k++) stim[k] = 4'(k * 5 + 1);
        run_sector(1'b0, 5, 0, 0, 1'b0, 1'b1, "startjunk");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read(1'b1, 40);
        t_write_read(1'b0, 20);
        t_mixed_gaps();
        t_after_done();
        t_empty_and_start_junk();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule